// File: doc/BRIEF.md
# Program/Data Space Memory Select Logic

This block drives the chip-select and output-enable lines of four memories: a segmented primary flash, a segmented secondary flash, an SRAM and an I/O block. They sit behind an 8051-style bus that has a program-fetch strobe and a data read strobe. An external address decoder supplies one hit line for each region. The block settles overlapping hits by a fixed three-level priority. A mapping register then decides whether the winning memory answers the strobe that is active.

The mapping register loads a configured value at reset. Software can rewrite it through a data write to a fixed offset in the control register region. A new value is held pending and takes effect at the start of the next bus cycle, which the bus signals with a one-clock pulse. The memory map therefore never changes partway through an access. With the reset value 0x0C, program fetches go to the primary flash and data reads go to everything else. Setting the two primary-flash bits places that flash in both spaces.

Top module: `space_mem_select`

## Requirements
- R1: After a synchronous active-low reset, the mapping register holds MAP_RESET (default 0x0C). A primary-flash hit then answers only the program strobe, and a secondary-flash hit answers only the data strobes.
- R2: Priority levels are: level 1 = SRAM, I/O and the control region; level 2 = secondary-flash segments; level 3 = primary-flash segments. Any hit on a higher level masks every hit on a lower level, even when the winning memory is not enabled for the active space.
- R3: Two or more hits on one level raise cfg_err. While cfg_err is high, every chip select and output enable is low.
- R4: The space is chosen from the strobes. prog_n low selects program space and takes precedence over the other strobes. Otherwise rd_n or wr_n low selects data space. With no strobe low, all chip selects and output enables are low.
- R5: Mapping bits are: bit0 = SRAM in program space, bit1 = secondary flash in program space, bit2 = primary flash in program space, bit3 = secondary flash in data space, bit4 = primary flash in data space.
- R6: SRAM and I/O are always enabled in data space. The I/O block is never selected in program space.
- R7: A chip select is high only for the winning region whose memory is enabled in the active space. An output enable equals its chip select while prog_n or rd_n is low, and it stays low during a write-only access.
- R8: A write updates the mapping register when all of these hold: wr_n is low, prog_n is high, the control region wins level 1 without conflict, and ctl_ofs equals MAP_OFFSET. The value map_wdata is held pending. It takes effect at the first later clock edge where cyc_start is high. A cyc_start in the same edge as the write does not apply it.
- R9: Writes at another offset, writes without a control-region hit, and writes during a configuration conflict leave the mapping unchanged.
- R10: Value 0x14 (bits 2 and 4) places the primary flash in combined space, so it answers both prog_n and rd_n.
- R11: Only the hitting segment of the winning flash gets its chip select. At most one chip select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_hit | input | NPF | Primary-flash segment hits (level 3) |
| sf_hit | input | NSF | Secondary-flash segment hits (level 2) |
| sram_hit | input | 1 | SRAM region hit (level 1) |
| io_hit | input | 1 | I/O block region hit (level 1) |
| ctl_hit | input | 1 | Control register region hit (level 1) |
| ctl_ofs | input | OFS_W | Offset within the control region |
| map_wdata | input | MAP_W | Write data for the mapping register |
| prog_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| cyc_start | input | 1 | One-clock pulse at the start of a bus cycle |
| pf_cs | output | NPF | Primary-flash segment chip selects |
| sf_cs | output | NSF | Secondary-flash segment chip selects |
| sram_cs | output | 1 | SRAM chip select |
| io_cs | output | 1 | I/O block chip select |
| pf_oe | output | 1 | Primary-flash output enable |
| sf_oe | output | 1 | Secondary-flash output enable |
| sram_oe | output | 1 | SRAM output enable |
| io_oe | output | 1 | I/O block output enable |
| cfg_err | output | 1 | Same-level overlap detected |

## Verification
A mapping-register write and a bus-cycle start pulse can fall on the same clock edge. In that case the decode of the current access must keep using the old map, and the pending value must wait for the next pulse. The bench drives the write and cyc_start together and probes with a primary-flash data read. It expects the old behaviour before and after that edge, and the new behaviour only after a later lone pulse. Random hit patterns, strobes and map values are compared against a bench model of the priority and space rules.

// File: rtl/msel_pkg.sv
// Shared constants and types for the memory select logic.
// Assumes a five-bit mapping register with the bit meanings below.
package msel_pkg;
    localparam int MAP_W     = 5;
    localparam int MB_SRAM_P = 0;
    localparam int MB_SF_P   = 1;
    localparam int MB_PF_P   = 2;
    localparam int MB_SF_D   = 3;
    localparam int MB_PF_D   = 4;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_PROG = 2'd1,
        SP_DATA = 2'd2
    } space_e;
endpackage

// File: rtl/msel_prio.sv
// Three-level priority resolver for decoded region hits.
// Level 1 = control/io/sram, level 2 = secondary flash, level 3 = primary flash.
// Assumes hits are combinational from the address decoder; a same-level
// overlap anywhere flags a conflict and suppresses every selection.
module msel_prio #(
    parameter int NPF = 4,
    parameter int NSF = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPF-1:0] pf_hit,
    input  logic [NSF-1:0] sf_hit,
    input  logic           sram_hit,
    input  logic           io_hit,
    input  logic           ctl_hit,
    output logic [NPF-1:0] pf_sel,
    output logic [NSF-1:0] sf_sel,
    output logic           sram_sel,
    output logic           io_sel,
    output logic           ctl_sel,
    output logic           conflict
);
    logic [2:0] lvl1;
    assign lvl1 = {ctl_hit, io_hit, sram_hit};

    // Detect more than one hit within any single level.
    always_comb begin
        conflict = ($countones(lvl1) > 1) || ($countones(sf_hit) > 1)
                || ($countones(pf_hit) > 1);
    end

    // Pass only the highest level that has a hit.
    always_comb begin
        pf_sel   = '0;
        sf_sel   = '0;
        sram_sel = 1'b0;
        io_sel   = 1'b0;
        ctl_sel  = 1'b0;
        if (!conflict) begin
            if (|lvl1) begin
                {ctl_sel, io_sel, sram_sel} = lvl1;
            end else if (|sf_hit) begin
                sf_sel = sf_hit;
            end else begin
                pf_sel = pf_hit;
            end
        end
    end

    // R11: at most one winner
    a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pf_sel, sf_sel, sram_sel, io_sel, ctl_sel}));
    // R2: a level-1 hit masks both flashes
    a_r2_level1_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_hit || io_hit || ctl_hit) |-> (pf_sel == '0 && sf_sel == '0));
    // R3: conflict selects nothing
    a_r3_conflict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> !(|{pf_sel, sf_sel, sram_sel, io_sel, ctl_sel}));
endmodule

// File: rtl/msel_mapreg.sv
// Mapping register with a deferred update.
// A qualified write stores into a pending slot; the slot is copied into the
// live register on the next cyc_start pulse, so the map never changes within
// a bus cycle. Synchronous active-low reset loads MAP_RESET.
module msel_mapreg
    import msel_pkg::*;
#(
    parameter int               OFS_W      = 8,
    parameter logic [OFS_W-1:0] MAP_OFFSET = 8'hB2,
    parameter logic [MAP_W-1:0] MAP_RESET  = 5'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [OFS_W-1:0] ofs,
    input  logic [MAP_W-1:0] wdata,
    input  logic             cyc_start,
    output logic [MAP_W-1:0] map_q
);
    logic [MAP_W-1:0] pend_q;
    logic             pend_v;
    logic             hit_reg;

    assign hit_reg = wr_req && (ofs == MAP_OFFSET);

    // Capture writes into the pending slot and apply them at cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= MAP_RESET;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (cyc_start && pend_v) begin
                map_q <= pend_q;
            end
            if (hit_reg) begin
                pend_q <= wdata;
                pend_v <= 1'b1;
            end else if (cyc_start) begin
                pend_v <= 1'b0;
            end
        end
    end

    // R8: the map holds between cycle starts
    a_r8_hold_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(map_q));
    // R1: first cycle out of reset shows the reset value
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (map_q == MAP_RESET));
endmodule

// File: rtl/msel_gate.sv
// Space gating: turns winning selections into chip selects and output
// enables according to the active strobe and the mapping register.
// Assumes strobes are active low; prog_n wins if several are low.
module msel_gate
    import msel_pkg::*;
#(
    parameter int NPF = 4,
    parameter int NSF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPF-1:0]   pf_sel,
    input  logic [NSF-1:0]   sf_sel,
    input  logic             sram_sel,
    input  logic             io_sel,
    input  logic [MAP_W-1:0] map_q,
    input  logic             prog_n,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic [NPF-1:0]   pf_cs,
    output logic [NSF-1:0]   sf_cs,
    output logic             sram_cs,
    output logic             io_cs,
    output logic             pf_oe,
    output logic             sf_oe,
    output logic             sram_oe,
    output logic             io_oe
);
    space_e sp;
    logic   pf_en, sf_en, sram_en, io_en, rd_act;

    // Pick the active address space from the strobes.
    always_comb begin
        if (!prog_n)             sp = SP_PROG;
        else if (!rd_n || !wr_n) sp = SP_DATA;
        else                     sp = SP_NONE;
    end

    // Per-memory enable in the active space.
    always_comb begin
        pf_en   = (sp == SP_PROG) ? map_q[MB_PF_P]   : (sp == SP_DATA) && map_q[MB_PF_D];
        sf_en   = (sp == SP_PROG) ? map_q[MB_SF_P]   : (sp == SP_DATA) && map_q[MB_SF_D];
        sram_en = (sp == SP_PROG) ? map_q[MB_SRAM_P] : (sp == SP_DATA);
        io_en   = (sp == SP_DATA);
        rd_act  = !prog_n || !rd_n;
    end

    for (genvar i = 0; i < NPF; i++) begin : g_pf
        assign pf_cs[i] = pf_sel[i] && pf_en;
    end
    for (genvar j = 0; j < NSF; j++) begin : g_sf
        assign sf_cs[j] = sf_sel[j] && sf_en;
    end

    assign sram_cs = sram_sel && sram_en;
    assign io_cs   = io_sel && io_en;
    assign pf_oe   = (|pf_cs) && rd_act;
    assign sf_oe   = (|sf_cs) && rd_act;
    assign sram_oe = sram_cs && rd_act;
    assign io_oe   = io_cs && rd_act;

    // R7: output enables are silent on write-only access
    a_r7_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_n && rd_n) |-> !(pf_oe || sf_oe || sram_oe || io_oe));
    // R6: I/O never answers a program fetch
    a_r6_io_not_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> !io_cs);
    // R4: no strobe, no select
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_n && rd_n && wr_n) |-> !(|{pf_cs, sf_cs, sram_cs, io_cs}));
endmodule

// File: rtl/space_mem_select.sv
// Top of the program/data space memory select logic.
// Resolves decoder hits by priority, gates them by the mapping register and
// strobe space, and owns the deferred-update mapping register.
module space_mem_select
    import msel_pkg::*;
#(
    parameter int               NPF        = 4,
    parameter int               NSF        = 2,
    parameter int               OFS_W      = 8,
    parameter logic [OFS_W-1:0] MAP_OFFSET = 8'hB2,
    parameter logic [MAP_W-1:0] MAP_RESET  = 5'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPF-1:0]   pf_hit,
    input  logic [NSF-1:0]   sf_hit,
    input  logic             sram_hit,
    input  logic             io_hit,
    input  logic             ctl_hit,
    input  logic [OFS_W-1:0] ctl_ofs,
    input  logic [MAP_W-1:0] map_wdata,
    input  logic             prog_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cyc_start,
    output logic [NPF-1:0]   pf_cs,
    output logic [NSF-1:0]   sf_cs,
    output logic             sram_cs,
    output logic             io_cs,
    output logic             pf_oe,
    output logic             sf_oe,
    output logic             sram_oe,
    output logic             io_oe,
    output logic             cfg_err
);
    logic [NPF-1:0]   pf_sel;
    logic [NSF-1:0]   sf_sel;
    logic             sram_sel, io_sel, ctl_sel, conflict;
    logic [MAP_W-1:0] map_q;
    logic             wr_req;

    msel_prio #(.NPF(NPF), .NSF(NSF)) u_prio (
        .clk(clk), .rst_n(rst_n),
        .pf_hit(pf_hit), .sf_hit(sf_hit), .sram_hit(sram_hit),
        .io_hit(io_hit), .ctl_hit(ctl_hit),
        .pf_sel(pf_sel), .sf_sel(sf_sel), .sram_sel(sram_sel),
        .io_sel(io_sel), .ctl_sel(ctl_sel), .conflict(conflict)
    );

    // A register write is a data-space write that lands on the control region.
    assign wr_req = !wr_n && prog_n && ctl_sel;

    msel_mapreg #(.OFS_W(OFS_W), .MAP_OFFSET(MAP_OFFSET), .MAP_RESET(MAP_RESET)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .ofs(ctl_ofs),
        .wdata(map_wdata), .cyc_start(cyc_start), .map_q(map_q)
    );

    msel_gate #(.NPF(NPF), .NSF(NSF)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .pf_sel(pf_sel), .sf_sel(sf_sel), .sram_sel(sram_sel), .io_sel(io_sel),
        .map_q(map_q), .prog_n(prog_n), .rd_n(rd_n), .wr_n(wr_n),
        .pf_cs(pf_cs), .sf_cs(sf_cs), .sram_cs(sram_cs), .io_cs(io_cs),
        .pf_oe(pf_oe), .sf_oe(sf_oe), .sram_oe(sram_oe), .io_oe(io_oe)
    );

    assign cfg_err = conflict;

    // R3: an error output silences every select at the pins
    a_r3_err_silences_pins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !(|{pf_cs, sf_cs, sram_cs, io_cs, pf_oe, sf_oe, sram_oe, io_oe}));
    // R11: chip selects one-hot at the pins
    a_r11_pins_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pf_cs, sf_cs, sram_cs, io_cs}));
endmodule

// File: tb/space_mem_select_test.sv
module space_mem_select_test;
    localparam int NPF = 4;
    localparam int NSF = 2;
    localparam logic [7:0] OFS = 8'hB2;
    localparam int OW = 1 + NPF + NSF + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPF-1:0] pf_hit = '0;
    logic [NSF-1:0] sf_hit = '0;
    logic sram_hit = 0, io_hit = 0, ctl_hit = 0;
    logic [7:0] ctl_ofs = '0;
    logic [4:0] map_wdata = '0;
    logic prog_n = 1, rd_n = 1, wr_n = 1, cyc_start = 0;
    logic [NPF-1:0] pf_cs;
    logic [NSF-1:0] sf_cs;
    logic sram_cs, io_cs, pf_oe, sf_oe, sram_oe, io_oe, cfg_err;

    int errors = 0;
    int checks = 0;
    logic [4:0] m_map, m_pend;
    logic m_pv;

    always #2.5 clk = ~clk;

    space_mem_select uut (
        .clk(clk), .rst_n(rst_n), .pf_hit(pf_hit), .sf_hit(sf_hit),
        .sram_hit(sram_hit), .io_hit(io_hit), .ctl_hit(ctl_hit),
        .ctl_ofs(ctl_ofs), .map_wdata(map_wdata), .prog_n(prog_n),
        .rd_n(rd_n), .wr_n(wr_n), .cyc_start(cyc_start),
        .pf_cs(pf_cs), .sf_cs(sf_cs), .sram_cs(sram_cs), .io_cs(io_cs),
        .pf_oe(pf_oe), .sf_oe(sf_oe), .sram_oe(sram_oe), .io_oe(io_oe),
        .cfg_err(cfg_err)
    );

    function automatic int ones(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return n;
    endfunction

    // Expected {cfg_err, pf_cs, sf_cs, sram_cs, io_cs, pf_oe, sf_oe, sram_oe, io_oe}
    function automatic logic [OW-1:0] model(logic [4:0] mp);
        logic err, prog, data, rdx;
        logic [NPF-1:0] pc;
        logic [NSF-1:0] sc;
        logic rc, ic;
        err = ones({5'b0, sram_hit, io_hit, ctl_hit}) > 1 ||
              ones({6'b0, sf_hit}) > 1 || ones({4'b0, pf_hit}) > 1;
        prog = !prog_n;
        data = prog_n && (!rd_n || !wr_n);
        rdx  = !prog_n || !rd_n;
        pc = '0; sc = '0; rc = 0; ic = 0;
        if (!err) begin
            if (sram_hit || io_hit || ctl_hit) begin
                rc = sram_hit && (data || (prog && mp[0]));
                ic = io_hit && data;
            end else if (sf_hit != 0) begin
                if ((prog && mp[1]) || (data && mp[3])) sc = sf_hit;
            end else begin
                if ((prog && mp[2]) || (data && mp[4])) pc = pf_hit;
            end
        end
        return {err, pc, sc, rc, ic, (|pc) && rdx, (|sc) && rdx, rc && rdx, ic && rdx};
    endfunction

    task automatic check(string tag);
        logic [OW-1:0] got, exp;
        #1;
        got = {cfg_err, pf_cs, sf_cs, sram_cs, io_cs, pf_oe, sf_oe, sram_oe, io_oe};
        exp = model(m_map);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic idle();
        pf_hit = '0; sf_hit = '0; sram_hit = 0; io_hit = 0; ctl_hit = 0;
        prog_n = 1; rd_n = 1; wr_n = 1; cyc_start = 0;
    endtask

    // One clock with the given write/cycle-start request, model updated after the edge.
    task automatic tick(logic wr, logic cyc, logic [7:0] ofs, logic [4:0] d);
        logic wvalid;
        @(negedge clk);
        idle();
        if (wr) begin ctl_hit = 1; wr_n = 0; ctl_ofs = ofs; map_wdata = d; end
        cyc_start = cyc;
        wvalid = wr && (ofs == OFS);
        @(posedge clk);
        if (cyc && m_pv) m_map = m_pend;
        if (wvalid) begin m_pend = d; m_pv = 1; end
        else if (cyc) m_pv = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic probe(logic [NPF-1:0] p, logic [NSF-1:0] s, logic r, logic i,
                         logic pr, logic rd, logic wr, string tag);
        @(negedge clk);
        idle();
        pf_hit = p; sf_hit = s; sram_hit = r; io_hit = i;
        prog_n = !pr; rd_n = !rd; wr_n = !wr;
        check(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        m_map = 5'h0C; m_pend = '0; m_pv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state and separate-space behaviour
        probe('0, '0, 0, 0, 0, 0, 0, "R1 idle after reset");
        probe(4'b0010, '0, 0, 0, 1, 0, 0, "R1 pf on program strobe");
        probe(4'b0010, '0, 0, 0, 0, 1, 0, "R1 pf absent on data read");
        probe('0, 2'b01, 0, 0, 0, 1, 0, "R1 sf on data read");
        probe('0, 2'b10, 0, 0, 1, 0, 0, "R5 sf absent in program space");
        // R2 priority
        probe(4'b0001, 2'b01, 1, 0, 0, 1, 0, "R2 sram over flashes");
        probe(4'b1000, 2'b10, 0, 0, 0, 1, 0, "R2 sf over pf");
        probe(4'b0100, '0, 1, 0, 1, 0, 0, "R2 sram masks pf in program space");
        // R3 conflicts
        probe('0, '0, 1, 1, 0, 1, 0, "R3 sram+io conflict");
        probe(4'b0011, '0, 0, 0, 1, 0, 0, "R3 pf segment conflict");
        // R4 / R6 / R7
        probe('0, '0, 0, 1, 1, 0, 0, "R6 io never in program space");
        probe('0, '0, 0, 1, 0, 0, 1, "R7 io write cs without oe");
        probe(4'b0100, '0, 0, 0, 1, 1, 0, "R4 program strobe precedence");
        probe('0, 2'b01, 0, 0, 0, 0, 0, "R4 no strobe idle");
        // R8: write and cycle start on the same edge leave the map alone
        tick(1, 1, OFS, 5'h14);
        probe(4'b1000, '0, 0, 0, 0, 1, 0, "R8 same-edge pulse not applied");
        tick(0, 0, OFS, 5'h00);
        probe(4'b1000, '0, 0, 0, 0, 1, 0, "R8 no pulse not applied");
        tick(0, 1, OFS, 5'h00);
        probe(4'b1000, '0, 0, 0, 0, 1, 0, "R10 pf combined data read");
        probe(4'b1000, '0, 0, 0, 1, 0, 0, "R10 pf combined program fetch");
        probe('0, 2'b01, 0, 0, 0, 1, 0, "R5 sf dropped from data space");
        // R9 ignored writes
        tick(1, 0, OFS + 8'd1, 5'h1F);
        tick(0, 1, OFS, 5'h00);
        probe('0, 2'b10, 0, 0, 1, 0, 0, "R9 wrong offset ignored");
        @(negedge clk);
        idle(); ctl_hit = 1; io_hit = 1; wr_n = 0; ctl_ofs = OFS; map_wdata = 5'h1F;
        @(posedge clk);
        tick(0, 1, OFS, 5'h00);
        probe('0, 2'b10, 0, 0, 1, 0, 0, "R9 write during conflict ignored");
        tick(1, 0, OFS, 5'h01);
        tick(0, 1, OFS, 5'h00);
        probe('0, '0, 1, 0, 1, 0, 0, "R5 sram in program space via bit0");
        // Random phase
        for (int k = 0; k < 400; k++) begin
            if (k % 40 == 0) begin
                tick(1, 0, OFS, 5'($urandom));
                tick(0, 1, OFS, 5'h00);
            end
            @(negedge clk);
            idle();
            pf_hit = ($urandom % 3 == 0) ? 4'($urandom) : 4'(($urandom % 2) << ($urandom % 4));
            sf_hit = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            sram_hit = ($urandom % 5 == 0);
            io_hit = ($urandom % 6 == 0);
            case ($urandom % 4)
                0: prog_n = 0;
                1: rd_n = 0;
                2: wr_n = 0;
                default: ;
            endcase
            check("R7 random access");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule